// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the CPU clock of a small microcontroller core runs, and in which of three low-power conditions the core sits. The instruction decoder sends it a one-cycle strobe when a wait-type or stop-type instruction executes. Pending interrupts bring the core back. Internal and external requests arrive on separate inputs, each already qualified by its local enable. The block drives the CPU clock enable and the interrupt mask bit. It also drives the enables for the PLL, the PLL output select, the oscillator and the clock-generator outputs, and a flag that tells the break comparator whether it may operate.

In wait the clock generator keeps running under whatever PLL settings software chose, and the break logic stays live. In stop everything is shut down, unless an oscillator-keep option was set when stop was entered. In that case only the PLL goes off. When stop ends with the oscillator cold, a stabilization count runs to completion before the CPU clock restarts. A break flag records whether each break occurred during wait, so that a handler can correct its return address.

Top module: `lpm_seq`

## Requirements
- R1: While reset is asserted and right after it, mode is RUN (code 2'b00), cpu_clk_en=1, imask=1, osc_en=1, cgm_out_en=1, brk_active=1, brk_in_wait=0 and pll_en=pll_sel=0.
- R2: In RUN, a stop_req strobe makes mode STOP (2'b10) at the next clock edge. Otherwise a wait_req strobe makes mode WAIT (2'b01) at the next edge. On entry to either mode, cpu_clk_en=0 and imask=0. Stop wins when both strobes arrive together.
- R3: In WAIT, irq_int or irq_ext returns mode to RUN at the next edge, with cpu_clk_en=1 and imask still 0.
- R4: In STOP, irq_int has no effect and mode stays STOP. Only irq_ext wakes the core.
- R5: A stop wake with the keep option clear enters STAB (2'b11). The mode stays STAB and cpu_clk_en stays 0 for exactly STAB_CYCLES samples after the wake edge, and then returns to RUN. With the keep option set, the wake goes straight to RUN.
- R6: Outside STOP, pll_en equals cfg_pll_on and pll_sel equals cfg_pll_on AND cfg_pll_sel, both one edge after the inputs. osc_en and cgm_out_en stay 1.
- R7: In STOP, pll_en=pll_sel=0. If cfg_osc_keep was 0 at the entry edge, osc_en=0 and cgm_out_en=0. If it was 1, both stay 1.
- R8: brk_active is 0 only in STOP. A brk_hit outside STOP loads brk_in_wait with 1 if the mode was WAIT and 0 otherwise. A brk_hit in STOP is ignored, and entering STOP leaves brk_in_wait unchanged.
- R9: Reset asserted in any mode returns the block to the R1 state, including imask=1.
- R10: A strobe that arrives in the same cycle as a wake interrupt still enters the mode. The block leaves the mode at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_req | input | 1 | Wait instruction strobe |
| stop_req | input | 1 | Stop instruction strobe |
| irq_int | input | 1 | Enabled internal interrupt pending |
| irq_ext | input | 1 | Enabled external interrupt pending |
| cfg_pll_on | input | 1 | Software PLL power setting |
| cfg_pll_sel | input | 1 | Software PLL output select setting |
| cfg_osc_keep | input | 1 | Keep oscillator running in stop |
| brk_hit | input | 1 | Break comparator match |
| mode | output | 2 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| imask | output | 1 | Interrupt mask bit |
| pll_en | output | 1 | PLL power enable |
| pll_sel | output | 1 | PLL output select |
| osc_en | output | 1 | Oscillator enable |
| cgm_out_en | output | 1 | Clock-generator output enable |
| brk_active | output | 1 | Break logic allowed to operate |
| brk_in_wait | output | 1 | Last break happened in wait |

## Verification
Every mode change, mask update and PLL enable is registered. These results therefore show up one edge after the strobe or interrupt that caused them. The bench drives inputs at the falling edge, lets one rising edge pass, and samples at the next falling edge. The oscillator and output gating follow the mode in the same sample. The stabilization window is counted sample by sample: the bench expects STAB on exactly STAB_CYCLES consecutive samples after the wake edge and RUN on the next one. It sweeps all PLL settings and both keep settings through wait and stop.

// File: rtl/lpm_seq.sv
module lpm_seq #(
  parameter int STAB_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       irq_int,
  input  logic       irq_ext,
  input  logic       cfg_pll_on,
  input  logic       cfg_pll_sel,
  input  logic       cfg_osc_keep,
  input  logic       brk_hit,
  output logic [1:0] mode,
  output logic       cpu_clk_en,
  output logic       imask,
  output logic       pll_en,
  output logic       pll_sel,
  output logic       osc_en,
  output logic       cgm_out_en,
  output logic       brk_active,
  output logic       brk_in_wait
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [1:0] M_RUN = 2'b00, M_WAIT = 2'b01, M_STOP = 2'b10, M_STAB = 2'b11;
  localparam logic [CW-1:0] CNT_LOAD = CW'(STAB_CYCLES - 1);

  logic [1:0]    st, nxt;
  logic [CW-1:0] cnt;
  logic          keep_q;

  always_comb begin
    nxt = st;
    unique case (st)
      M_RUN:  if (stop_req) nxt = M_STOP;
              else if (wait_req) nxt = M_WAIT;
      M_WAIT: if (irq_int || irq_ext) nxt = M_RUN;
      M_STOP: if (irq_ext) nxt = keep_q ? M_RUN : M_STAB;
      M_STAB: if (cnt == '0) nxt = M_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= M_RUN;
      cnt         <= '0;
      keep_q      <= 1'b0;
      imask       <= 1'b1;
      pll_en      <= 1'b0;
      pll_sel     <= 1'b0;
      brk_in_wait <= 1'b0;
    end else begin
      st <= nxt;
      if (st == M_RUN && stop_req) keep_q <= cfg_osc_keep;
      if (st == M_STOP) cnt <= CNT_LOAD;
      else if (st == M_STAB && cnt != '0) cnt <= cnt - 1'b1;
      if (st == M_RUN && (stop_req || wait_req)) imask <= 1'b0;
      pll_en  <= cfg_pll_on && nxt != M_STOP;
      pll_sel <= cfg_pll_on && cfg_pll_sel && nxt != M_STOP;
      if (brk_hit && st != M_STOP) brk_in_wait <= (st == M_WAIT);
    end
  end

  assign mode       = st;
  assign cpu_clk_en = (st == M_RUN);
  assign osc_en     = !(st == M_STOP && !keep_q);
  assign cgm_out_en = osc_en;
  assign brk_active = (st != M_STOP);
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wait_req,
  input logic       stop_req,
  input logic       irq_int,
  input logic       irq_ext,
  input logic       cfg_pll_on,
  input logic       cfg_osc_keep,
  input logic       brk_hit,
  input logic [1:0] mode,
  input logic       cpu_clk_en,
  input logic       imask,
  input logic       pll_en,
  input logic       osc_en,
  input logic       cgm_out_en,
  input logic       brk_in_wait
);
  p_enter_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && (wait_req || stop_req)) |=> (!cpu_clk_en && !imask));

  p_wait_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && (irq_int || irq_ext)) |=> (mode == 2'b00 && cpu_clk_en && !imask));

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !irq_ext) |=> (mode == 2'b10));

  p_stop_cold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && stop_req && !cfg_osc_keep) |=> (!osc_en && !cgm_out_en && !pll_en));

  p_stop_warm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && stop_req && cfg_osc_keep) |=> (osc_en && !pll_en));

  p_brk_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && brk_hit) |=> $stable(brk_in_wait));

  p_stab_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> (!cpu_clk_en && osc_en));

  p_pll_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !irq_int && !irq_ext) |=> (pll_en == $past(cfg_pll_on)));
endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
  .irq_int(irq_int), .irq_ext(irq_ext), .cfg_pll_on(cfg_pll_on),
  .cfg_osc_keep(cfg_osc_keep), .brk_hit(brk_hit), .mode(mode),
  .cpu_clk_en(cpu_clk_en), .imask(imask), .pll_en(pll_en), .osc_en(osc_en),
  .cgm_out_en(cgm_out_en), .brk_in_wait(brk_in_wait)
);

// File: tb/tb_lpm_seq.sv
module tb_lpm_seq;
  localparam int STAB = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, irq_int = 0, irq_ext = 0;
  logic cfg_pll_on = 0, cfg_pll_sel = 0, cfg_osc_keep = 0, brk_hit = 0;
  logic [1:0] mode;
  logic cpu_clk_en, imask, pll_en, pll_sel, osc_en, cgm_out_en, brk_active, brk_in_wait;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lpm_seq #(.STAB_CYCLES(STAB)) dut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle_in();
    wait_req = 0; stop_req = 0; irq_int = 0; irq_ext = 0; brk_hit = 0;
  endtask

  task automatic chk_run(input string req);
    chk(req, "mode", mode, 0);
    chk(req, "cpu_clk_en", cpu_clk_en, 1);
    chk(req, "osc_en", osc_en, 1);
    chk(req, "cgm_out_en", cgm_out_en, 1);
    chk(req, "brk_active", brk_active, 1);
  endtask

  task automatic do_reset();
    rst_n = 0; idle_in();
    #1;
    chk("R9", "mode in reset", mode, 0);
    chk("R9", "imask in reset", imask, 1);
    chk("R1", "pll_en in reset", pll_en, 0);
    chk("R1", "pll_sel in reset", pll_sel, 0);
    chk("R1", "brk_in_wait in reset", brk_in_wait, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk_run("R1");
    chk("R1", "imask", imask, 1);

    for (int cfg = 0; cfg < 8; cfg++) begin
      cfg_pll_on = cfg[0]; cfg_pll_sel = cfg[1]; cfg_osc_keep = cfg[2];
      tick();
      chk("R6", "pll_en run", pll_en, cfg[0]);
      chk("R6", "pll_sel run", pll_sel, cfg[0] & cfg[1]);
      wait_req = 1; tick(); idle_in();
      chk("R2", "mode wait", mode, 1);
      chk("R2", "cpu_clk_en wait", cpu_clk_en, 0);
      chk("R2", "imask wait", imask, 0);
      chk("R6", "pll_en wait", pll_en, cfg[0]);
      chk("R6", "pll_sel wait", pll_sel, cfg[0] & cfg[1]);
      chk("R6", "osc_en wait", osc_en, 1);
      chk("R8", "brk_active wait", brk_active, 1);
      brk_hit = 1; tick(); brk_hit = 0;
      chk("R8", "brk_in_wait", brk_in_wait, 1);
      if (cfg[0]) irq_int = 1; else irq_ext = 1;
      tick(); idle_in();
      chk_run("R3");
      chk("R3", "imask after wake", imask, 0);
      stop_req = 1; tick(); idle_in();
      chk("R2", "mode stop", mode, 2);
      chk("R7", "pll_en stop", pll_en, 0);
      chk("R7", "pll_sel stop", pll_sel, 0);
      chk("R7", "osc_en stop", osc_en, cfg[2]);
      chk("R7", "cgm_out_en stop", cgm_out_en, cfg[2]);
      chk("R8", "brk_active stop", brk_active, 0);
      cfg_osc_keep = ~cfg[2];
      irq_int = 1; brk_hit = 1; tick(); idle_in();
      chk("R4", "mode after irq_int", mode, 2);
      chk("R8", "brk_in_wait frozen", brk_in_wait, 1);
      chk("R7", "keep latched at entry", osc_en, cfg[2]);
      irq_ext = 1; tick(); idle_in();
      if (cfg[2]) chk_run("R5");
      else begin
        chk("R5", "mode stab", mode, 3);
        chk("R5", "cpu_clk_en stab", cpu_clk_en, 0);
        chk("R6", "pll_en stab", pll_en, cfg[0]);
        for (int i = 1; i < STAB; i++) begin
          tick();
          chk("R5", "mode stab hold", mode, 3);
        end
        tick();
        chk_run("R5");
      end
      chk("R3", "imask after stop", imask, 0);
      brk_hit = 1; tick(); brk_hit = 0;
      chk("R8", "brk_in_wait run", brk_in_wait, 0);
      cfg_osc_keep = cfg[2];
    end

    wait_req = 1; stop_req = 1; cfg_osc_keep = 1; tick(); idle_in();
    chk("R2", "stop priority", mode, 2);
    irq_ext = 1; tick(); idle_in();
    chk_run("R5");

    wait_req = 1; irq_int = 1; tick(); wait_req = 0;
    chk("R10", "entered wait", mode, 1);
    tick(); idle_in();
    chk("R10", "left wait", mode, 0);
    stop_req = 1; irq_ext = 1; tick(); stop_req = 0;
    chk("R10", "entered stop", mode, 2);
    tick(); idle_in();
    chk("R10", "left stop", mode, 0);

    cfg_osc_keep = 0; stop_req = 1; tick(); idle_in();
    irq_ext = 1; tick(); idle_in(); tick();
    chk("R9", "in stab before reset", mode, 3);
    do_reset();
    chk_run("R9");
    chk("R9", "imask after reset", imask, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule